// File: doc/BRIEF.md
# PIRQ to Global Interrupt Router

This block sits between eight level-sensitive PCI interrupt request lines (PIRQ A to H) plus a system control interrupt (SCI) level, and the 24 global interrupt inputs of a platform's two interrupt controllers. Pins 0 to 15 go to the legacy controller and pins 16 to 23 go to the advanced controller. Each PIRQ always drives its own advanced pin. It can also be steered onto a legacy pin, and several PIRQs may share that pin.

Eight byte-wide routing registers and one control byte are loaded through a simple write port. The control byte holds a three-bit field that picks the pin carrying the SCI. That field may change while the SCI is asserted, and the block then hands the SCI over cleanly from the old pin to the new one. A query port reports how any one PIRQ is currently routed. A strobe tells the surrounding logic that a routing byte was written.

Top module: `pirq_gsi_router`

## Requirements
- R1: After reset all 24 pin outputs and the strobe are low. Every routing byte reads as 0x80 (legacy routing off), and the SCI select field is 0.
- R2: Routing byte k for PIRQ k (k = 0..3) is written at ROUTE_LO_BASE+k, and for k = 4..7 at ROUTE_HI_BASE+k-4. In the byte, bit 7 set turns legacy routing off. Bits 4:0 give the legacy IRQ number, and bits 6:5 are ignored.
- R3: Legacy pin n (n < 16) is the OR of every PIRQ whose bit 7 is clear and whose IRQ number equals n. A PIRQ whose IRQ number is 16 or above drives no legacy pin.
- R4: Pin 16+k follows PIRQ k at all times, whatever its routing byte holds.
- R5: Bits 2:0 of the byte at ACPI_CTL_ADDR select the SCI pin: code 0 gives 9, 1 gives 10, 2 gives 11, 4 gives 20 and 5 gives 21. The SCI level is ORed into the selected pin.
- R6: Select codes 3, 6 and 7 are reserved. With one of them the SCI reaches no pin.
- R7: If the select field is written with a new value while the SCI input is high, the SCI first drops from the old pin for one output cycle, during which it reaches no pin. It then appears on the new pin.
- R8: The query for PIRQ qry_pirq is returned one clock later. It reports mode 0 (legacy) with the IRQ number when legacy routing is on and the IRQ is below 16. It reports mode 2 (disabled) with IRQ 0 when the IRQ is 16 or above. It reports mode 1 (advanced) with IRQ 16+k when legacy routing is off.
- R9: A write to any routing byte raises route_chg for exactly the next cycle. A write to the control byte or to any other address does not raise it.
- R10: Pin outputs reflect the PIRQ and SCI inputs present at the previous clock edge. A register write changes the pins at the second edge after the write.
- R11: Writes to addresses other than the eight routing bytes and the control byte change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write data |
| pirq_in | input | 8 | PIRQ A..H levels, bit k is PIRQ k |
| sci_in | input | 1 | SCI level |
| qry_pirq | input | 3 | PIRQ index to query |
| gsi_out | output | 24 | Global interrupt pin levels |
| route_chg | output | 1 | One-cycle pulse after a routing byte write |
| qry_mode | output | 2 | Query mode: 0 legacy, 1 advanced, 2 disabled |
| qry_irq | output | 5 | Query result pin number |

## Verification
On every cycle the assertions check several properties. Each advanced pin follows its PIRQ. All pins go quiet when no source is active. A reserved SCI code with no PIRQ active leaves every pin low. The routing-byte strobe follows each routing write, and the handover gap lasts a single cycle. Only the bench scenarios can show the finer behaviours: that legacy pins are shared by OR, that the exact pin is chosen for each select code, that the SCI moves from the old pin through a silent cycle to the new one, that the query result is right in every mode, and that stray writes leave the routing untouched.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

  localparam int IRQ_W = 5;

  typedef enum logic [1:0] {
    QRY_LEGACY   = 2'd0,
    QRY_ADVANCED = 2'd1,
    QRY_DISABLED = 2'd2
  } qry_mode_e;

  typedef struct packed {
    logic             legacy_off;
    logic [IRQ_W-1:0] irq;
  } route_t;

  typedef struct packed {
    logic             valid;
    logic [IRQ_W-1:0] pin;
  } sci_tgt_t;

  localparam route_t ROUTE_RESET = '{legacy_off: 1'b1, irq: '0};

  function automatic route_t byte_to_route(input logic [7:0] b);
    route_t r;
    r.legacy_off = b[7];
    r.irq        = b[IRQ_W-1:0];
    return r;
  endfunction

  function automatic sci_tgt_t sci_decode(input logic [2:0] sel);
    sci_tgt_t t;
    t.valid = 1'b1;
    case (sel)
      3'd0:    t.pin = 5'd9;
      3'd1:    t.pin = 5'd10;
      3'd2:    t.pin = 5'd11;
      3'd4:    t.pin = 5'd20;
      3'd5:    t.pin = 5'd21;
      default: begin t.valid = 1'b0; t.pin = '0; end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int          PIRQ_N        = 8,
  parameter int          GROUP_N       = 4,
  parameter logic [7:0]  ROUTE_LO_BASE = 8'h60,
  parameter logic [7:0]  ROUTE_HI_BASE = 8'h68,
  parameter logic [7:0]  ACPI_CTL_ADDR = 8'h44
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              wr_addr,
  input  logic [7:0]              wr_data,
  input  logic                    sci_in,
  output route_t [PIRQ_N-1:0]     routes,
  output logic [2:0]              sci_sel,
  output logic                    sci_hold,
  output logic                    route_chg
);

  logic [PIRQ_N-1:0] route_hit;
  logic              ctl_hit;

  assign ctl_hit = wr_en && (wr_addr == ACPI_CTL_ADDR);

  for (genvar k = 0; k < PIRQ_N; k++) begin : g_route
    localparam logic [7:0] ADDR_K = (k < GROUP_N) ? ROUTE_LO_BASE + 8'(k)
                                                  : ROUTE_HI_BASE + 8'(k - GROUP_N);
    assign route_hit[k] = wr_en && (wr_addr == ADDR_K);

    always_ff @(posedge clk) begin
      if (!rst_n)            routes[k] <= ROUTE_RESET;
      else if (route_hit[k]) routes[k] <= byte_to_route(wr_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sci_sel   <= '0;
      sci_hold  <= 1'b0;
      route_chg <= 1'b0;
    end else begin
      route_chg <= |route_hit;
      sci_hold  <= ctl_hit && sci_in && (wr_data[2:0] != sci_sel);
      if (ctl_hit) sci_sel <= wr_data[2:0];
    end
  end

  p_strobe_follows_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|route_hit) |=> route_chg);

  p_no_strobe_on_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit || !wr_en) |=> !route_chg);

  p_hold_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_hold && !ctl_hit) |=> !sci_hold);

endmodule

// File: rtl/pirq_level_merge.sv
module pirq_level_merge
  import pirq_router_pkg::*;
#(
  parameter int PIRQ_N   = 8,
  parameter int LEGACY_N = 16,
  localparam int OUT_N   = LEGACY_N + PIRQ_N
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PIRQ_N-1:0]   pirq_in,
  input  logic                sci_in,
  input  route_t [PIRQ_N-1:0] routes,
  input  logic [2:0]          sci_sel,
  input  logic                sci_hold,
  output logic [OUT_N-1:0]    gsi_q
);

  logic [OUT_N-1:0] gsi_nxt;
  sci_tgt_t         sci_tgt;
  logic             sci_live;

  assign sci_tgt  = sci_decode(sci_sel);
  assign sci_live = sci_in && !sci_hold && sci_tgt.valid;

  always_comb begin
    gsi_nxt = '0;
    for (int k = 0; k < PIRQ_N; k++) begin
      gsi_nxt[LEGACY_N + k] = pirq_in[k];
      if (!routes[k].legacy_off && (int'(routes[k].irq) < LEGACY_N))
        gsi_nxt[routes[k].irq] = gsi_nxt[routes[k].irq] | pirq_in[k];
    end
    if (sci_live && (int'(sci_tgt.pin) < OUT_N))
      gsi_nxt[sci_tgt.pin] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gsi_q <= '0;
    else        gsi_q <= gsi_nxt;
  end

  for (genvar k = 0; k < PIRQ_N; k++) begin : g_adv_chk
    p_adv_follows_pirq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pirq_in[k] |=> gsi_q[LEGACY_N + k]);
  end

  p_quiet_without_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_in == '0 && !sci_in) |=> (gsi_q == '0));

  p_reserved_sci_nowhere_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_in == '0 && (sci_sel == 3'd3 || sci_sel == 3'd6 || sci_sel == 3'd7))
      |=> (gsi_q == '0));

endmodule

// File: rtl/pirq_route_query.sv
module pirq_route_query
  import pirq_router_pkg::*;
#(
  parameter int PIRQ_N   = 8,
  parameter int LEGACY_N = 16,
  localparam int SEL_W   = $clog2(PIRQ_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    qry_pirq,
  input  route_t [PIRQ_N-1:0] routes,
  output qry_mode_e           qry_mode_q,
  output logic [IRQ_W-1:0]    qry_irq_q
);

  route_t           sel_route;
  qry_mode_e        mode_nxt;
  logic [IRQ_W-1:0] irq_nxt;

  assign sel_route = routes[qry_pirq];

  always_comb begin
    if (sel_route.legacy_off) begin
      mode_nxt = QRY_ADVANCED;
      irq_nxt  = IRQ_W'(LEGACY_N) + IRQ_W'(qry_pirq);
    end else if (int'(sel_route.irq) < LEGACY_N) begin
      mode_nxt = QRY_LEGACY;
      irq_nxt  = sel_route.irq;
    end else begin
      mode_nxt = QRY_DISABLED;
      irq_nxt  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qry_mode_q <= QRY_ADVANCED;
      qry_irq_q  <= IRQ_W'(LEGACY_N);
    end else begin
      qry_mode_q <= mode_nxt;
      qry_irq_q  <= irq_nxt;
    end
  end

  p_adv_pin_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_mode_q == QRY_ADVANCED) |-> (int'(qry_irq_q) >= LEGACY_N));

  p_legacy_pin_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_mode_q == QRY_LEGACY) |-> (int'(qry_irq_q) < LEGACY_N));

endmodule

// File: rtl/pirq_gsi_router.sv
module pirq_gsi_router
  import pirq_router_pkg::*;
#(
  parameter int          PIRQ_N        = 8,
  parameter int          LEGACY_N      = 16,
  parameter logic [7:0]  ROUTE_LO_BASE = 8'h60,
  parameter logic [7:0]  ROUTE_HI_BASE = 8'h68,
  parameter logic [7:0]  ACPI_CTL_ADDR = 8'h44,
  localparam int         OUT_N         = LEGACY_N + PIRQ_N,
  localparam int         SEL_W         = $clog2(PIRQ_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [PIRQ_N-1:0]  pirq_in,
  input  logic               sci_in,
  input  logic [SEL_W-1:0]   qry_pirq,
  output logic [OUT_N-1:0]   gsi_out,
  output logic               route_chg,
  output logic [1:0]         qry_mode,
  output logic [IRQ_W-1:0]   qry_irq
);

  route_t [PIRQ_N-1:0] routes;
  logic [2:0]          sci_sel;
  logic                sci_hold;
  qry_mode_e           mode_q;

  pirq_route_regs #(
    .PIRQ_N(PIRQ_N), .GROUP_N(PIRQ_N / 2),
    .ROUTE_LO_BASE(ROUTE_LO_BASE), .ROUTE_HI_BASE(ROUTE_HI_BASE),
    .ACPI_CTL_ADDR(ACPI_CTL_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sci_in(sci_in), .routes(routes),
    .sci_sel(sci_sel), .sci_hold(sci_hold), .route_chg(route_chg)
  );

  pirq_level_merge #(.PIRQ_N(PIRQ_N), .LEGACY_N(LEGACY_N)) u_merge (
    .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in),
    .routes(routes), .sci_sel(sci_sel), .sci_hold(sci_hold), .gsi_q(gsi_out)
  );

  pirq_route_query #(.PIRQ_N(PIRQ_N), .LEGACY_N(LEGACY_N)) u_query (
    .clk(clk), .rst_n(rst_n), .qry_pirq(qry_pirq), .routes(routes),
    .qry_mode_q(mode_q), .qry_irq_q(qry_irq)
  );

  assign qry_mode = mode_q;

endmodule

// File: tb/pirq_gsi_router_bench.sv
`timescale 1ns/1ps
module pirq_gsi_router_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  pirq_in = '0;
  logic        sci_in = 1'b0;
  logic [2:0]  qry_pirq = '0;
  logic [23:0] gsi_out;
  logic        route_chg;
  logic [1:0]  qry_mode;
  logic [4:0]  qry_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] m_route [8];
  logic [2:0] m_sel;

  always #10 clk = ~clk;

  pirq_gsi_router u_pirq_gsi_router (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pirq_in(pirq_in), .sci_in(sci_in),
    .qry_pirq(qry_pirq), .gsi_out(gsi_out), .route_chg(route_chg),
    .qry_mode(qry_mode), .qry_irq(qry_irq)
  );

  function automatic logic [7:0] addr_of(input int k);
    return (k < 4) ? 8'h60 + 8'(k) : 8'h68 + 8'(k - 4);
  endfunction

  function automatic int sci_pin(input logic [2:0] s);
    case (s)
      3'd0: return 9;
      3'd1: return 10;
      3'd2: return 11;
      3'd4: return 20;
      3'd5: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [23:0] exp_gsi(input logic [7:0] p, input logic s);
    logic [23:0] e = '0;
    for (int k = 0; k < 8; k++) begin
      if (p[k]) begin
        e[16 + k] = 1'b1;
        if (!m_route[k][7] && m_route[k][4:0] < 5'd16) e[m_route[k][4:0]] = 1'b1;
      end
    end
    if (s && sci_pin(m_sel) >= 0) e[sci_pin(m_sel)] = 1'b1;
    return e;
  endfunction

  function automatic logic [6:0] exp_qry(input int k);
    if (m_route[k][7])                  return {2'd1, 5'(16 + k)};
    else if (m_route[k][4:0] < 5'd16)   return {2'd0, m_route[k][4:0]};
    else                                return {2'd2, 5'd0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
    for (int k = 0; k < 8; k++) if (a == addr_of(k)) m_route[k] = d;
    if (a == 8'h44) m_sel = d[2:0];
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 8; k++) m_route[k] = 8'h80;
    m_sel = 3'd0;
    qry_pirq = 3'd2;
    repeat (3) step();
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 gsi", gsi_out, 24'h0);
    chk("R1 strobe", route_chg, 1'b0);
    step();
    chk("R1 route default query", {qry_mode, qry_irq}, {2'd1, 5'd18});

    // R4 / R10: advanced pin follows after one edge
    pirq_in = 8'h01;
    step();
    chk("R4 R10 adv only", gsi_out, 24'h01_0000);
    // R10: write routing byte, old routing still visible one edge later
    wr(8'h60, 8'h05);
    chk("R10 write latency", gsi_out, 24'h01_0000);
    chk("R9 strobe high", route_chg, 1'b1);
    step();
    chk("R2 R10 legacy 5", gsi_out, 24'h01_0020);
    chk("R9 strobe low", route_chg, 1'b0);

    // R3: share pin 5 with PIRQ B, bits 6:5 ignored (0x65 -> irq 5)
    wr(8'h61, 8'h65);
    step();
    pirq_in = 8'h02;
    step();
    chk("R3 R2 shared pin", gsi_out, 24'h02_0020);
    pirq_in = 8'h03;
    step();
    chk("R3 OR both", gsi_out, 24'h03_0020);
    // R2 upper group: PIRQ F at second base
    wr(8'h69, 8'h07);
    pirq_in = 8'h20;
    step();
    chk("R2 hi group", gsi_out, 24'h20_0080);
    // R3: irq >= 16 drives no legacy pin
    wr(8'h69, 8'h12);
    step();
    chk("R3 irq ge16", gsi_out, 24'h20_0000);
    // R8 query modes
    qry_pirq = 3'd5; step();
    chk("R8 disabled", {qry_mode, qry_irq}, {2'd2, 5'd0});
    qry_pirq = 3'd1; step();
    chk("R8 legacy", {qry_mode, qry_irq}, {2'd0, 5'd5});
    qry_pirq = 3'd7; step();
    chk("R8 advanced", {qry_mode, qry_irq}, {2'd1, 5'd23});

    // R11: stray writes change nothing
    wr(8'h64, 8'h03);
    chk("R9 no strobe stray", route_chg, 1'b0);
    wr(8'h45, 8'h02);
    pirq_in = 8'h02;
    step();
    chk("R11 routing intact", gsi_out, 24'h02_0020);
    qry_pirq = 3'd4; step();
    chk("R11 query intact", {qry_mode, qry_irq}, {2'd1, 5'd20});

    // R5: SCI on pin 9 by default
    pirq_in = 8'h00; sci_in = 1'b1;
    step();
    chk("R5 sci pin9", gsi_out, 24'h00_0200);
    // R7: move to code 4 (pin 20) while asserted
    wr(8'h44, 8'h04);
    chk("R9 no strobe ctl", route_chg, 1'b0);
    chk("R7 old pin before move", gsi_out, 24'h00_0200);
    step();
    chk("R7 gap cycle", gsi_out, 24'h0);
    step();
    chk("R7 R5 new pin20", gsi_out, 24'h10_0000);
    // R6: reserved code
    wr(8'h44, 8'h06);
    step(); step();
    chk("R6 reserved", gsi_out, 24'h0);
    sci_in = 1'b0;
    wr(8'h44, 8'h05);
    sci_in = 1'b1;
    step();
    chk("R5 pin21", gsi_out, 24'h20_0000);
    sci_in = 1'b0;
    step();

    // Random phase: R3 R4 R5 R8
    for (int it = 0; it < 60; it++) begin
      int k = $urandom % 8;
      logic [7:0] b = {1'($urandom % 2), 2'($urandom % 4), 5'($urandom % 24)};
      sci_in = 1'b0;
      wr(addr_of(k), b);
      if ($urandom % 3 == 0) wr(8'h44, 8'($urandom % 8));
      step();
      for (int c = 0; c < 4; c++) begin
        logic [7:0] p = 8'($urandom);
        logic s = 1'($urandom % 2);
        int q = $urandom % 8;
        pirq_in = p; sci_in = s; qry_pirq = 3'(q);
        step();
        chk("R3 R4 R5 random gsi", gsi_out, exp_gsi(p, s));
        chk("R8 random query", {qry_mode, qry_irq}, exp_qry(q));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule